// File: doc/BRIEF.md
# Single-Correct Double-Detect Hamming Codec

This block protects a data word with a Hamming code extended by one whole-word parity bit. The encoder side takes a data word and, one clock later, presents a codeword in which check bits sit at the power-of-two positions and data bits fill the gaps. The decoder side takes a codeword, possibly damaged, and one clock later returns the data with any single flipped bit repaired. It also gives the raw syndrome and exactly one of three outcome flags: intact, corrected, or uncorrectable double error.

The data width is a parameter. The number of check bits is derived from it as the smallest count that can name every codeword position plus the no-error case. Four data bits give an 8-bit codeword. Sixty-four data bits give a 72-bit codeword. The encoder and decoder are independent pipelines that share one clock and one reset, so a memory controller can place one on its write path and the other on its read path.

Top module: `secded_codec`

## Requirements
- R1: With DATA_W data bits, the check-bit count E is the smallest value with 2^E >= DATA_W + E + 1. The codeword has DATA_W + E + 1 bits: 8 bits for DATA_W = 4 and 72 bits for DATA_W = 64.
- R2: Codeword bit 0 is the whole-word parity bit. Codeword bit p, for p from 1 to DATA_W + E, holds Hamming position p. Positions that are powers of two hold check bits. Data bit i goes to the i-th non-power-of-two position, counting upward.
- R3: The check bit at position 2^k is the XOR of every other position whose index has bit k set. Bit 0 makes the total count of ones in the codeword even.
- R4: enc_valid_o rises exactly one cycle after enc_valid_i, and enc_code_o then holds the codeword of the data captured on that edge.
- R5: A codeword with zero syndrome and even total parity is reported as clean, with the data unchanged.
- R6: A codeword with exactly one flipped bit at position p (1 to DATA_W + E) yields syndrome value p. The decoder restores that bit and raises the corrected flag. For example, a flip at position 5 of the 8-bit code yields syndrome 5.
- R7: A flip of bit 0 alone yields syndrome 0 with odd total parity. It is reported as corrected, and the data passes through unchanged.
- R8: Two flipped bits at distinct positions a and b yield syndrome a XOR b, where bit 0 counts as position 0. The double flag is raised.
- R9: dec_valid_o rises exactly one cycle after dec_valid_i. Exactly one of the three flags is high while dec_valid_o is high, and all three are low otherwise.
- R10: After reset, both valid outputs and all decoder flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| enc_valid_i | input | 1 | Encoder input strobe |
| enc_data_i | input | DATA_W | Data word to encode |
| enc_valid_o | output | 1 | Encoder output strobe |
| enc_code_o | output | DATA_W+E+1 | Encoded codeword |
| dec_valid_i | input | 1 | Decoder input strobe |
| dec_code_i | input | DATA_W+E+1 | Codeword to check |
| dec_valid_o | output | 1 | Decoder output strobe |
| dec_data_o | output | DATA_W | Corrected data |
| dec_syndrome_o | output | E | Syndrome of the received word |
| dec_clean_o | output | 1 | No error found |
| dec_corrected_o | output | 1 | Single error repaired |
| dec_double_o | output | 1 | Double error detected, data not repaired |

## Verification
The outcomes that are hard to reach from the ports are the damaged-word classes. A normal write path only ever produces clean words, so a bit in the overall parity position or a pair of bits never arrives by chance. The bench therefore computes reference codewords arithmetically, using the XOR of the positions of the set data bits, and then flips each codeword bit in turn, including bit 0. It then flips every pair for the 4-bit code, and a spread of pairs on pseudo-random 64-bit words. For each case it compares the syndrome with the flipped position, or with the XOR of both positions.

// File: rtl/secded_pkg.sv
package secded_pkg;

    // Smallest E such that E check bits can address DATA_W + E positions plus "no error"
    function automatic int check_bits(input int data_w);
        for (int e = 1; e < 32; e++) begin
            if ((64'd1 << e) >= 64'(data_w + e + 1)) return e;
        end
        return 32;
    endfunction

    function automatic bit is_pow2(input int p);
        return (p > 0) && ((p & (p - 1)) == 0);
    endfunction

    typedef enum logic [1:0] {
        KIND_CLEAN  = 2'd0,
        KIND_SINGLE = 2'd1,
        KIND_DOUBLE = 2'd2
    } dec_kind_e;

    typedef struct packed {
        logic clean;
        logic corrected;
        logic double_err;
    } dec_flags_t;

    function automatic dec_flags_t kind_to_flags(input dec_kind_e kind);
        dec_flags_t f;
        f.clean      = (kind == KIND_CLEAN);
        f.corrected  = (kind == KIND_SINGLE);
        f.double_err = (kind == KIND_DOUBLE);
        return f;
    endfunction

endpackage

// File: rtl/secded_encoder.sv
module secded_encoder
    import secded_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 valid_i,
    input  logic [DATA_W-1:0]    data_i,
    output logic                 valid_o,
    output logic [DATA_W+check_bits(DATA_W):0] code_o
);
    localparam int E  = check_bits(DATA_W);
    localparam int N  = DATA_W + E;
    localparam int CW = N + 1;

    logic [N:0]   scatter;   // data placed at non-power positions, check slots zero
    logic [E-1:0] chk;
    logic [CW-1:0] code_next;

    // Place data bits into the gaps between power-of-two positions
    always_comb begin
        int di;
        di = 0;
        scatter = '0;
        for (int p = 1; p <= N; p++) begin
            if (!is_pow2(p)) begin
                scatter[p] = data_i[di];
                di++;
            end
        end
    end

    // One parity tree per check bit
    for (genvar k = 0; k < E; k++) begin : g_chk
        always_comb begin
            chk[k] = 1'b0;
            for (int p = 1; p <= N; p++) begin
                if (((p >> k) & 1) == 1) chk[k] = chk[k] ^ scatter[p];
            end
        end
    end

    always_comb begin
        code_next = CW'(scatter);
        for (int k = 0; k < E; k++) code_next[1 << k] = chk[k];
        code_next[0] = ^code_next[N:1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            code_o  <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) code_o <= code_next;
        end
    end

    a_r4_enc_latency: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> valid_o);
    a_r4_enc_idle: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> !valid_o);

endmodule

// File: rtl/secded_syndrome.sv
module secded_syndrome
    import secded_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W+check_bits(DATA_W):0] code_i,
    output logic [check_bits(DATA_W)-1:0]       syndrome_o,
    output logic                                odd_o
);
    localparam int E = check_bits(DATA_W);
    localparam int N = DATA_W + E;

    for (genvar k = 0; k < E; k++) begin : g_syn
        always_comb begin
            syndrome_o[k] = 1'b0;
            for (int p = 1; p <= N; p++) begin
                if (((p >> k) & 1) == 1) syndrome_o[k] = syndrome_o[k] ^ code_i[p];
            end
        end
    end

    assign odd_o = ^code_i;

endmodule

// File: rtl/secded_decoder.sv
module secded_decoder
    import secded_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                valid_i,
    input  logic [DATA_W+check_bits(DATA_W):0]  code_i,
    output logic                                valid_o,
    output logic [DATA_W-1:0]                   data_o,
    output logic [check_bits(DATA_W)-1:0]       syndrome_o,
    output dec_flags_t                          flags_o
);
    localparam int E  = check_bits(DATA_W);
    localparam int N  = DATA_W + E;
    localparam int CW = N + 1;

    logic [E-1:0]  syn;
    logic          odd;
    logic [CW-1:0] fixed;
    logic [DATA_W-1:0] data_next;
    dec_kind_e     kind;

    secded_syndrome #(.DATA_W(DATA_W)) i_syndrome (
        .code_i     (code_i),
        .syndrome_o (syn),
        .odd_o      (odd)
    );

    // Classify and repair
    always_comb begin
        fixed = code_i;
        if (syn == '0) begin
            kind = odd ? KIND_SINGLE : KIND_CLEAN;   // odd: only bit 0 flipped
        end else if (odd && (int'(syn) <= N)) begin
            fixed[syn] = ~code_i[syn];
            kind = KIND_SINGLE;
        end else begin
            kind = KIND_DOUBLE;
        end
    end

    // Gather data bits back from the non-power positions
    always_comb begin
        int di;
        di = 0;
        data_next = '0;
        for (int p = 1; p <= N; p++) begin
            if (!is_pow2(p)) begin
                data_next[di] = fixed[p];
                di++;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o    <= 1'b0;
            data_o     <= '0;
            syndrome_o <= '0;
            flags_o    <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                data_o     <= data_next;
                syndrome_o <= syn;
                flags_o    <= kind_to_flags(kind);
            end else begin
                flags_o    <= '0;
            end
        end
    end

    a_r9_dec_latency: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> valid_o);
    a_r9_one_flag: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $countones(flags_o) == 1);
    a_r9_flags_idle: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> flags_o == '0);
    a_r5_clean_zero_syn: assert property (@(posedge clk) disable iff (rst)
        (valid_o && flags_o.clean) |-> syndrome_o == '0);
    a_r8_double_nonzero: assert property (@(posedge clk) disable iff (rst)
        (valid_o && flags_o.double_err) |-> syndrome_o != '0);

endmodule

// File: rtl/secded_codec.sv
module secded_codec
    import secded_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                enc_valid_i,
    input  logic [DATA_W-1:0]                   enc_data_i,
    output logic                                enc_valid_o,
    output logic [DATA_W+check_bits(DATA_W):0]  enc_code_o,
    input  logic                                dec_valid_i,
    input  logic [DATA_W+check_bits(DATA_W):0]  dec_code_i,
    output logic                                dec_valid_o,
    output logic [DATA_W-1:0]                   dec_data_o,
    output logic [check_bits(DATA_W)-1:0]       dec_syndrome_o,
    output logic                                dec_clean_o,
    output logic                                dec_corrected_o,
    output logic                                dec_double_o
);
    dec_flags_t flags;

    secded_encoder #(.DATA_W(DATA_W)) i_encoder (
        .clk     (clk),
        .rst     (rst),
        .valid_i (enc_valid_i),
        .data_i  (enc_data_i),
        .valid_o (enc_valid_o),
        .code_o  (enc_code_o)
    );

    secded_decoder #(.DATA_W(DATA_W)) i_decoder (
        .clk        (clk),
        .rst        (rst),
        .valid_i    (dec_valid_i),
        .code_i     (dec_code_i),
        .valid_o    (dec_valid_o),
        .data_o     (dec_data_o),
        .syndrome_o (dec_syndrome_o),
        .flags_o    (flags)
    );

    assign dec_clean_o     = flags.clean;
    assign dec_corrected_o = flags.corrected;
    assign dec_double_o    = flags.double_err;

    a_r10_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!enc_valid_o && !dec_valid_o && !dec_clean_o
                        && !dec_corrected_o && !dec_double_o));

endmodule

// File: tb/test_secded_codec.sv
module codec_harness
    import secded_pkg::*;
#(
    parameter int DATA_W = 4,
    parameter int EXP_CW = 8,
    parameter int N_WORDS = 16
) (
    input  logic clk,
    input  logic rst,
    output logic done,
    output int   n_checks,
    output int   n_fails
);
    localparam int E  = check_bits(DATA_W);
    localparam int N  = DATA_W + E;
    localparam int CW = N + 1;

    logic              enc_valid_i = 1'b0;
    logic [DATA_W-1:0] enc_data_i  = '0;
    logic              enc_valid_o;
    logic [CW-1:0]     enc_code_o;
    logic              dec_valid_i = 1'b0;
    logic [CW-1:0]     dec_code_i  = '0;
    logic              dec_valid_o;
    logic [DATA_W-1:0] dec_data_o;
    logic [E-1:0]      dec_syndrome_o;
    logic              dec_clean_o, dec_corrected_o, dec_double_o;

    secded_codec #(.DATA_W(DATA_W)) i_secded_codec (
        .clk(clk), .rst(rst),
        .enc_valid_i(enc_valid_i), .enc_data_i(enc_data_i),
        .enc_valid_o(enc_valid_o), .enc_code_o(enc_code_o),
        .dec_valid_i(dec_valid_i), .dec_code_i(dec_code_i),
        .dec_valid_o(dec_valid_o), .dec_data_o(dec_data_o),
        .dec_syndrome_o(dec_syndrome_o),
        .dec_clean_o(dec_clean_o), .dec_corrected_o(dec_corrected_o),
        .dec_double_o(dec_double_o)
    );

    task automatic check(input bit ok, input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s (W=%0d): actual %h expected %h", tag, DATA_W, act, exp);
        end
    endtask

    // Reference: check bits equal the XOR of the position numbers of set data bits
    function automatic logic [CW-1:0] ref_encode(input logic [DATA_W-1:0] d);
        logic [CW-1:0] c;
        int acc, di;
        c = '0; acc = 0; di = 0;
        for (int p = 1; p <= N; p++) begin
            if ((p & (p - 1)) != 0) begin
                c[p] = d[di];
                if (d[di]) acc = acc ^ p;
                di++;
            end
        end
        for (int k = 0; k < E; k++) c[1 << k] = ((acc >> k) & 1) == 1;
        c[0] = ($countones(c) % 2) == 1;
        return c;
    endfunction

    task automatic do_encode(input logic [DATA_W-1:0] d);
        logic [CW-1:0] exp;
        exp = ref_encode(d);
        @(negedge clk);
        enc_valid_i = 1'b1; enc_data_i = d;
        @(negedge clk);
        enc_valid_i = 1'b0;
        check(enc_valid_o == 1'b1, "R4 enc valid", 128'(enc_valid_o), 128'd1);
        check(enc_code_o == exp, "R2 R3 codeword", 128'(enc_code_o), 128'(exp));
    endtask

    // kind: 0 clean, 1 corrected, 2 double
    task automatic do_decode(input logic [CW-1:0] code, input logic [DATA_W-1:0] exp_d,
                             input int kind, input int exp_syn, input string tag);
        logic [2:0] exp_f, act_f;
        exp_f = (kind == 0) ? 3'b100 : (kind == 1) ? 3'b010 : 3'b001;
        @(negedge clk);
        dec_valid_i = 1'b1; dec_code_i = code;
        @(negedge clk);
        dec_valid_i = 1'b0;
        act_f = {dec_clean_o, dec_corrected_o, dec_double_o};
        check(dec_valid_o == 1'b1, {tag, " R9 valid"}, 128'(dec_valid_o), 128'd1);
        check(act_f == exp_f, {tag, " R9 flags"}, 128'(act_f), 128'(exp_f));
        check(int'(dec_syndrome_o) == exp_syn, {tag, " syndrome"},
              128'(dec_syndrome_o), 128'(exp_syn));
        if (kind != 2)
            check(dec_data_o == exp_d, {tag, " data"}, 128'(dec_data_o), 128'(exp_d));
    endtask

    initial begin
        logic [63:0] x;
        logic [DATA_W-1:0] d;
        logic [CW-1:0] c;
        done = 1'b0; n_checks = 0; n_fails = 0;
        x = 64'h9E37_79B9_7F4A_7C15;
        wait (rst == 1'b0);
        @(negedge clk);
        // R10: reset state
        check({enc_valid_o, dec_valid_o, dec_clean_o, dec_corrected_o, dec_double_o} == 5'b0,
              "R10 reset outputs", 128'({enc_valid_o, dec_valid_o, dec_clean_o,
              dec_corrected_o, dec_double_o}), 128'd0);
        // R1: codeword width
        check(CW == EXP_CW && $bits(enc_code_o) == EXP_CW, "R1 width",
              128'($bits(enc_code_o)), 128'(EXP_CW));
        for (int w = 0; w < N_WORDS; w++) begin
            if (DATA_W <= 8) d = DATA_W'(w);
            else begin
                x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
                d = DATA_W'(x);
            end
            c = ref_encode(d);
            do_encode(d);
            do_decode(c, d, 0, 0, "R5 clean");
            // R9: flags low while idle (one cycle after the strobe dropped)
            @(negedge clk);
            check({dec_valid_o, dec_clean_o, dec_corrected_o, dec_double_o} == 4'b0,
                  "R9 idle flags", 128'({dec_valid_o, dec_clean_o, dec_corrected_o,
                  dec_double_o}), 128'd0);
            for (int b = 0; b < CW; b++) begin
                logic [CW-1:0] cb;
                cb = c; cb[b] = ~cb[b];
                if (b == 0) do_decode(cb, d, 1, 0, "R7 parity-bit flip");
                else        do_decode(cb, d, 1, b, "R6 single flip");
            end
            if (DATA_W <= 8) begin
                for (int a = 0; a < CW; a++)
                    for (int b = a + 1; b < CW; b++) begin
                        logic [CW-1:0] cd;
                        cd = c; cd[a] = ~cd[a]; cd[b] = ~cd[b];
                        do_decode(cd, d, 2, a ^ b, "R8 double flip");
                    end
            end else begin
                for (int t = 0; t < 12; t++) begin
                    int a, b;
                    logic [CW-1:0] cd;
                    a = (w * 13 + t * 5) % CW;
                    b = (a + 1 + (t * 7) % (CW - 1)) % CW;
                    cd = c; cd[a] = ~cd[a]; cd[b] = ~cd[b];
                    do_decode(cd, d, 2, a ^ b, "R8 double flip");
                end
            end
        end
        done = 1'b1;
    end
endmodule

module test_secded_codec;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic done4, done64, timeout;
    int   c4, f4, c64, f64;

    always #5 clk = ~clk;

    codec_harness #(.DATA_W(4),  .EXP_CW(8),  .N_WORDS(16)) h_w4 (
        .clk(clk), .rst(rst), .done(done4), .n_checks(c4), .n_fails(f4));
    codec_harness #(.DATA_W(64), .EXP_CW(72), .N_WORDS(24)) h_w64 (
        .clk(clk), .rst(rst), .done(done64), .n_checks(c64), .n_fails(f64));

    initial begin
        timeout = 1'b0;
        repeat (200000) @(posedge clk);
        timeout = 1'b1;
    end

    initial begin
        int total, fails;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        wait ((done4 && done64) || timeout);
        total = c4 + c64;
        fails = f4 + f64;
        if (timeout) begin
            total++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", total, fails);
        $finish;
    end
endmodule